// File: doc/BRIEF.md
# LCD Initialisation Script Player

This block brings a display panel out of reset and plays a packed start-up script to it over an 8-bit, 8080-style write-only bus. After the panel reset pulse and a settling wait, it steps through an internal script ROM. Each ROM entry is either a plain byte or a marker. A command marker makes the next plain byte go out as a command. The plain bytes that follow it, up to the next marker, go out as parameters. A delay marker takes the next entry as a wait in milliseconds. An end marker stops playback and raises `done`.

The controller is a state machine with seven states. `S_RST_LOW` drives the panel reset low. When the reset-low count is reached it moves to `S_RST_WAIT`, which holds the settling time with chip select asserted. When that count is reached it moves to `S_FETCH`, which decodes the current entry. From `S_FETCH`:
- A command marker stays in `S_FETCH` and arms command mode.
- A delay marker moves to `S_DLY_ARG`.
- An end marker moves to `S_DONE`.
- A plain byte starts a bus write and moves to `S_SEND`.

`S_SEND` returns to `S_FETCH` when the write completes. `S_DLY_ARG` starts the millisecond timer and moves to `S_DLY_WAIT`; a zero argument goes straight back to `S_FETCH`. `S_DLY_WAIT` returns to `S_FETCH` when the timer expires. `S_DONE` is terminal. The bus writer (`W_IDLE`, `W_SETUP`, `W_LOW`, `W_HIGH`) and the millisecond timer are separate submodules.

Top module: `lcd_init_player`

## Requirements
- R1: While `rst_n` is low, `lcd_rst_n` is 0, `lcd_wr_n` is 1 and `done` is 0. `lcd_rst_n` rises on the RST_LOW_CYC-th rising clock edge after `rst_n` is released.
- R2: Chip select `lcd_cs_n` is 0 from the rise of `lcd_rst_n` until `done` rises. `lcd_wr_n` is never 0 while `lcd_cs_n` is 1 or `lcd_rst_n` is 0. The first strobe falls at least RST_WAIT_CYC cycles after `lcd_rst_n` rises.
- R3: Each script entry is 10 bits, {tag[1:0], value[7:0]}. Tag 2'b01 is a command marker, 2'b10 a delay marker, 2'b11 the end marker and 2'b00 a plain byte. The first plain byte after a command marker goes out with `lcd_dc`=0. Every later plain byte goes out with `lcd_dc`=1.
- R4: Every byte holds `lcd_wr_n` low for exactly WR_LOW_CYC cycles. Between two strobes `lcd_wr_n` is high for at least WR_HIGH_CYC cycles. `lcd_db` and `lcd_dc` are set while the strobe is high and do not change while it is low.
- R5: A delay marker takes the next entry's value as N milliseconds. No strobe occurs for at least N*CLK_HZ/1000 cycles.
- R6: On the end marker `done` rises and stays 1, `lcd_cs_n` returns to 1, and no further strobes occur.
- R7: The default script writes these 18 bytes in order, shown as dc:value: 0:B0 1:00 0:11 0:3A 1:55 0:C5 1:00 1:1E 1:80 0:36 1:28 0:E0 1:00 1:04 1:0E 1:08 0:11 0:29. This includes pixel format command 3A with parameter 55, which selects 16 bits per pixel.
- R8: After the first sleep-out command 0x11, at least 120 ms pass before the next strobe falls.
- R9: The last two bytes of the default script are the commands 0x11 and 0x29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; playback starts on release |
| lcd_rst_n | output | 1 | Panel reset, active low |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_dc | output | 1 | 0 = command byte, 1 = parameter byte |
| lcd_wr_n | output | 1 | Write strobe, active low; the panel latches on its rise |
| lcd_db | output | 8 | Parallel data bus |
| done | output | 1 | Script finished |

## Verification
The only input is reset, so the assertions assume that `rst_n` is released once and then stays high. They also assume that the ROM script contains an end marker before its last address and never places a delay marker directly before the end marker. The bench keeps to this: it applies one clean reset and then lets the built-in script run to completion. With the bench's clock rate parameter, a millisecond is eight cycles, so the 120 ms wait stays short.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

    typedef enum logic [1:0] {
        TAG_VAL = 2'b00,
        TAG_CMD = 2'b01,
        TAG_DLY = 2'b10,
        TAG_END = 2'b11
    } tag_e;

    typedef struct packed {
        tag_e       tag;
        logic [7:0] val;
    } entry_t;

    function automatic entry_t mk(input tag_e t, input logic [7:0] v);
        entry_t e;
        e.tag = t;
        e.val = v;
        return e;
    endfunction

endpackage

// File: rtl/lcd_script_rom.sv
module lcd_script_rom
    import lcd_init_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output entry_t            entry
);

    always_comb begin
        case (int'(addr))
            0:  entry = mk(TAG_CMD, 8'h00);
            1:  entry = mk(TAG_VAL, 8'hB0);
            2:  entry = mk(TAG_VAL, 8'h00);
            3:  entry = mk(TAG_CMD, 8'h00);
            4:  entry = mk(TAG_VAL, 8'h11);
            5:  entry = mk(TAG_DLY, 8'h00);
            6:  entry = mk(TAG_VAL, 8'd120);
            7:  entry = mk(TAG_CMD, 8'h00);
            8:  entry = mk(TAG_VAL, 8'h3A);
            9:  entry = mk(TAG_VAL, 8'h55);
            10: entry = mk(TAG_CMD, 8'h00);
            11: entry = mk(TAG_VAL, 8'hC5);
            12: entry = mk(TAG_VAL, 8'h00);
            13: entry = mk(TAG_VAL, 8'h1E);
            14: entry = mk(TAG_VAL, 8'h80);
            15: entry = mk(TAG_CMD, 8'h00);
            16: entry = mk(TAG_VAL, 8'h36);
            17: entry = mk(TAG_VAL, 8'h28);
            18: entry = mk(TAG_CMD, 8'h00);
            19: entry = mk(TAG_VAL, 8'hE0);
            20: entry = mk(TAG_VAL, 8'h00);
            21: entry = mk(TAG_VAL, 8'h04);
            22: entry = mk(TAG_VAL, 8'h0E);
            23: entry = mk(TAG_VAL, 8'h08);
            24: entry = mk(TAG_CMD, 8'h00);
            25: entry = mk(TAG_VAL, 8'h11);
            26: entry = mk(TAG_CMD, 8'h00);
            27: entry = mk(TAG_VAL, 8'h29);
            default: entry = mk(TAG_END, 8'h00);
        endcase
    end

endmodule

// File: rtl/lcd_ms_timer.sv
module lcd_ms_timer #(
    parameter int CYC_PER_MS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] ms,
    output logic       busy,
    output logic       done
);

    localparam int PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;

    logic          active_q;
    logic [PW-1:0] pre_q;
    logic [7:0]    left_q;
    logic          wrap;

    assign wrap = (pre_q == PW'(CYC_PER_MS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            pre_q    <= '0;
            left_q   <= '0;
        end else if (start && !active_q) begin
            active_q <= (ms != 8'd0);
            pre_q    <= '0;
            left_q   <= ms;
        end else if (active_q) begin
            if (wrap) begin
                pre_q  <= '0;
                left_q <= left_q - 8'd1;
                if (left_q == 8'd1) begin
                    active_q <= 1'b0;
                end
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    always_comb begin
        busy = active_q;
        done = active_q && wrap && (left_q == 8'd1);
    end

    // R5: a running wait always has milliseconds left to count
    a_r5_left_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (left_q != 8'd0));

endmodule

// File: rtl/lcd_bus_writer.sv
module lcd_bus_writer #(
    parameter int WR_LOW_CYC  = 2,
    parameter int WR_HIGH_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       is_cmd,
    input  logic [7:0] byte_in,
    output logic       done,
    output logic       wr_n,
    output logic       dc,
    output logic [7:0] db
);

    localparam int MAXC = (WR_LOW_CYC > WR_HIGH_CYC) ? WR_LOW_CYC : WR_HIGH_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef enum logic [1:0] {W_IDLE, W_SETUP, W_LOW, W_HIGH} wstate_e;

    wstate_e       st_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= W_IDLE;
            cnt_q <= '0;
            dc    <= 1'b1;
            db    <= '0;
        end else begin
            unique case (st_q)
                W_IDLE: begin
                    if (start) begin
                        db   <= byte_in;
                        dc   <= !is_cmd;
                        st_q <= W_SETUP;
                    end
                end
                W_SETUP: begin
                    cnt_q <= CW'(WR_LOW_CYC - 1);
                    st_q  <= W_LOW;
                end
                W_LOW: begin
                    if (cnt_q == '0) begin
                        cnt_q <= CW'(WR_HIGH_CYC - 1);
                        st_q  <= W_HIGH;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                W_HIGH: begin
                    if (cnt_q == '0) begin
                        st_q <= W_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        wr_n = (st_q != W_LOW);
        done = (st_q == W_HIGH) && (cnt_q == '0);
    end

    // R4: bus lines frozen while the strobe is low
    a_r4_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(!wr_n)) |-> ($stable(db) && $stable(dc)));

    // R4: a new byte is only taken while idle, never mid-strobe
    a_r4_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && st_q != W_IDLE) |=> $stable(db));

endmodule

// File: rtl/lcd_init_player.sv
module lcd_init_player
    import lcd_init_pkg::*;
#(
    parameter int CLK_HZ       = 125_000_000,
    parameter int WR_LOW_CYC   = 2,
    parameter int WR_HIGH_CYC  = 2,
    parameter int RST_LOW_CYC  = 1250,
    parameter int RST_WAIT_CYC = 625_000,
    parameter int ADDR_W       = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       lcd_rst_n,
    output logic       lcd_cs_n,
    output logic       lcd_dc,
    output logic       lcd_wr_n,
    output logic [7:0] lcd_db,
    output logic       done
);

    localparam int CYC_PER_MS = CLK_HZ / 1000;
    localparam int PH_MAX     = (RST_LOW_CYC > RST_WAIT_CYC) ? RST_LOW_CYC : RST_WAIT_CYC;
    localparam int PHW        = $clog2(PH_MAX + 1);

    typedef enum logic [2:0] {
        S_RST_LOW, S_RST_WAIT, S_FETCH, S_SEND, S_DLY_ARG, S_DLY_WAIT, S_DONE
    } state_e;

    state_e            state_q, state_d;
    logic [PHW-1:0]    ph_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              cmd_next_q;
    entry_t            ent;
    logic              wr_start, wr_done;
    logic              tmr_start, tmr_done, tmr_busy;
    logic              advance;

    lcd_script_rom #(.ADDR_W(ADDR_W)) i_rom (
        .addr  (ptr_q),
        .entry (ent)
    );

    lcd_bus_writer #(.WR_LOW_CYC(WR_LOW_CYC), .WR_HIGH_CYC(WR_HIGH_CYC)) i_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (wr_start),
        .is_cmd  (cmd_next_q),
        .byte_in (ent.val),
        .done    (wr_done),
        .wr_n    (lcd_wr_n),
        .dc      (lcd_dc),
        .db      (lcd_db)
    );

    lcd_ms_timer #(.CYC_PER_MS(CYC_PER_MS)) i_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .ms    (ent.val),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    // next-state and strobe decode
    always_comb begin
        state_d   = state_q;
        wr_start  = 1'b0;
        tmr_start = 1'b0;
        unique case (state_q)
            S_RST_LOW:  if (ph_q == PHW'(RST_LOW_CYC - 1)) state_d = S_RST_WAIT;
            S_RST_WAIT: if (ph_q == PHW'(RST_WAIT_CYC - 1)) state_d = S_FETCH;
            S_FETCH: begin
                unique case (ent.tag)
                    TAG_CMD: state_d = S_FETCH;
                    TAG_DLY: state_d = S_DLY_ARG;
                    TAG_END: state_d = S_DONE;
                    TAG_VAL: begin
                        wr_start = 1'b1;
                        state_d  = S_SEND;
                    end
                endcase
            end
            S_SEND:     if (wr_done) state_d = S_FETCH;
            S_DLY_ARG: begin
                if (ent.val != 8'd0) begin
                    tmr_start = 1'b1;
                    state_d   = S_DLY_WAIT;
                end else begin
                    state_d = S_FETCH;
                end
            end
            S_DLY_WAIT: if (tmr_done) state_d = S_FETCH;
            S_DONE:     state_d = S_DONE;
        endcase
    end

    assign advance = ((state_q == S_FETCH) && (ent.tag != TAG_END)) || (state_q == S_DLY_ARG);

    // state register and script pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_RST_LOW;
            ph_q       <= '0;
            ptr_q      <= '0;
            cmd_next_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                ph_q <= '0;
            end else if (state_q == S_RST_LOW || state_q == S_RST_WAIT) begin
                ph_q <= ph_q + 1'b1;
            end
            if (advance) begin
                ptr_q <= ptr_q + 1'b1;
            end
            if (state_q == S_FETCH && ent.tag == TAG_CMD) begin
                cmd_next_q <= 1'b1;
            end else if (state_q == S_FETCH && ent.tag == TAG_VAL) begin
                cmd_next_q <= 1'b0;
            end
        end
    end

    // panel control outputs
    always_comb begin
        lcd_rst_n = (state_q != S_RST_LOW);
        lcd_cs_n  = (state_q == S_RST_LOW) || (state_q == S_DONE);
        done      = (state_q == S_DONE);
    end

    // R6: done never drops once reached
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R6: bus quiet and deselected after the end marker
    a_r6_quiet_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lcd_wr_n && lcd_cs_n));

    // R2: a strobe only while selected and out of reset
    a_r2_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_wr_n |-> (!lcd_cs_n && lcd_rst_n));

    // R5: no bus activity during a timed wait
    a_r5_quiet_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |-> lcd_wr_n);

    // R3: first byte after a command marker is a command
    a_r3_cmd_dc: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH && ent.tag == TAG_VAL && cmd_next_q) |=> !lcd_dc);

    // R3: later bytes are parameters
    a_r3_param_dc: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH && ent.tag == TAG_VAL && !cmd_next_q) |=> lcd_dc);

endmodule

// File: tb/test_lcd_init_player.sv
`timescale 1ns/1ps
module test_lcd_init_player;

    localparam int CLK_HZ   = 8000;
    localparam int CPM      = CLK_HZ / 1000;
    localparam int WR_LOW   = 2;
    localparam int WR_HIGH  = 3;
    localparam int RST_LOW  = 20;
    localparam int RST_WAIT = 30;
    localparam int NEXP     = 18;

    localparam logic [8:0] EXP [NEXP] = '{
        9'h0B0, 9'h100, 9'h011, 9'h03A, 9'h155, 9'h0C5, 9'h100, 9'h11E, 9'h180,
        9'h036, 9'h128, 9'h0E0, 9'h100, 9'h104, 9'h10E, 9'h108, 9'h011, 9'h029};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lcd_rst_n, lcd_cs_n, lcd_dc, lcd_wr_n, done;
    logic [7:0] lcd_db;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lcd_init_player #(
        .CLK_HZ(CLK_HZ), .WR_LOW_CYC(WR_LOW), .WR_HIGH_CYC(WR_HIGH),
        .RST_LOW_CYC(RST_LOW), .RST_WAIT_CYC(RST_WAIT), .ADDR_W(5)
    ) i_lcd_init_player (
        .clk(clk), .rst_n(rst_n), .lcd_rst_n(lcd_rst_n), .lcd_cs_n(lcd_cs_n),
        .lcd_dc(lcd_dc), .lcd_wr_n(lcd_wr_n), .lcd_db(lcd_db), .done(done)
    );

    // bus monitor, sampled on the falling clock edge
    int         cyc = 0;
    int         n = 0;
    logic [8:0] got [32];
    int         fall_t [32];
    int         rise_t [32];
    int         hi_viol = 0, stab_viol = 0, cs_viol = 0;
    int         rst_rise_t = -1;
    logic       prev_wr = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (lcd_rst_n && rst_rise_t < 0) rst_rise_t = cyc;
            if (lcd_rst_n && !done && lcd_cs_n) cs_viol++;
            if (!lcd_wr_n && (lcd_cs_n || !lcd_rst_n)) cs_viol++;
            if (n < 32) begin
                if (prev_wr && !lcd_wr_n) begin
                    fall_t[n] = cyc;
                    got[n]    = {lcd_dc, lcd_db};
                    if (n > 0 && (cyc - rise_t[n-1]) < WR_HIGH) hi_viol++;
                end else if (!prev_wr && !lcd_wr_n) begin
                    if ({lcd_dc, lcd_db} != got[n]) stab_viol++;
                end else if (!prev_wr && lcd_wr_n) begin
                    rise_t[n] = cyc;
                    n++;
                end
            end
            prev_wr = lcd_wr_n;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset_state;   // R1
        repeat (3) @(negedge clk);
        chk(lcd_rst_n == 1'b0, "R1", "panel reset low in reset", int'(lcd_rst_n), 0);
        chk(lcd_wr_n == 1'b1, "R1", "strobe idle in reset", int'(lcd_wr_n), 1);
        chk(done == 1'b0, "R1", "done low in reset", int'(done), 0);
        #2 rst_n = 1'b1;
    endtask

    task automatic t_reset_pulse;   // R1, R2
        chk(rst_rise_t == RST_LOW, "R1", "panel reset rise cycle", rst_rise_t, RST_LOW);
        chk((fall_t[0] - rst_rise_t) >= RST_WAIT, "R2", "settle before first strobe",
            fall_t[0] - rst_rise_t, RST_WAIT);
        chk((fall_t[0] - rst_rise_t) <= RST_WAIT + 4, "R2", "first strobe not late",
            fall_t[0] - rst_rise_t, RST_WAIT + 4);
        chk(cs_viol == 0, "R2", "select violations", cs_viol, 0);
    endtask

    task automatic t_sequence;      // R3, R7, R9
        chk(n == NEXP, "R7", "byte count", n, NEXP);
        for (int i = 0; i < NEXP; i++) begin
            chk(got[i][7:0] == EXP[i][7:0], "R7", $sformatf("byte %0d value", i),
                int'(got[i][7:0]), int'(EXP[i][7:0]));
            chk(got[i][8] == EXP[i][8], "R3", $sformatf("byte %0d dc", i),
                int'(got[i][8]), int'(EXP[i][8]));
        end
        chk(got[3] == 9'h03A && got[4] == 9'h155, "R7", "pixel format pair",
            int'(got[4]), 9'h155);
        chk(got[NEXP-2] == 9'h011, "R9", "sleep-out near end", int'(got[NEXP-2]), 9'h011);
        chk(got[NEXP-1] == 9'h029, "R9", "display-on last", int'(got[NEXP-1]), 9'h029);
    endtask

    task automatic t_strobe;        // R4
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            if ((rise_t[i] - fall_t[i]) != WR_LOW) bad++;
        end
        chk(bad == 0, "R4", "strobes with wrong low width", bad, 0);
        chk((rise_t[0] - fall_t[0]) == WR_LOW, "R4", "first low width",
            rise_t[0] - fall_t[0], WR_LOW);
        chk(hi_viol == 0, "R4", "short high gaps", hi_viol, 0);
        chk(stab_viol == 0, "R4", "bus changes while low", stab_viol, 0);
    endtask

    task automatic t_delay;         // R5, R8
        int gap = fall_t[3] - rise_t[2];
        chk(gap >= 120 * CPM, "R8", "wait after sleep-out", gap, 120 * CPM);
        chk(gap <= 120 * CPM + 20, "R5", "wait not overlong", gap, 120 * CPM + 20);
    endtask

    task automatic t_end;           // R6
        int n0 = n;
        repeat (100) @(negedge clk);
        chk(done == 1'b1, "R6", "done held", int'(done), 1);
        chk(n == n0, "R6", "no strobes after end", n, n0);
        chk(lcd_cs_n == 1'b1, "R6", "deselected after end", int'(lcd_cs_n), 1);
        chk(lcd_wr_n == 1'b1, "R6", "strobe idle after end", int'(lcd_wr_n), 1);
    endtask

    initial begin
        t_reset_state();
        wait (done === 1'b1);
        @(negedge clk);
        t_reset_pulse();
        t_sequence();
        t_strobe();
        t_delay();
        t_end();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: done never reached actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule